// File: doc/BRIEF.md
# Serial-Loaded Bank Configuration Registers

This block holds the bank configuration of a cartridge memory mapper whose registers can only be reached one data bit at a time. Each CPU write to the upper half of the 16-bit address space carries a single payload bit in data bit 0. A five-bit collector with a marker bit counts the bits as they arrive. The fifth accepted write stores the assembled five-bit value into one of four configuration registers. Address bits 14 and 13 of that fifth write pick the register.

A write with data bit 7 set aborts a partial load at any point. The outputs are the decoded fields that the address translation logic uses: nametable mirroring, program bank mode, character bank mode, two character bank numbers, the program bank number and a work-RAM enable. The CPU write port has no back-pressure. Every strobed write is taken on the clock edge where `wr_en` is high, and the outputs are plain levels.

Top module: `bank_cfg_serial`

## Requirements
- R1: After reset, `mirror_mode`=0, `prg_mode`=3, `chr_split`=0, `chr_bank_lo`=0, `chr_bank_hi`=0, `prg_bank`=0 and `wram_en`=0, and the collector holds no bits.
- R2: A strobed write with `wr_addr[15]`=1 and `wr_data[7]`=1 discards any partially collected bits and commits nothing. The next accepted write counts as the first of a new five-write load.
- R3: Payload bits arrive least significant first. The k-th accepted write supplies `wr_data[0]` as bit k-1 of the value, and `wr_data[6:1]` has no effect.
- R4: The fifth accepted write commits the value. `wr_addr[14:13]` of that write selects the target: 0 is control, 1 is the low character bank (`chr_bank_lo` = value), 2 is the high character bank (`chr_bank_hi` = value) and 3 is the program bank register. Registers that were not targeted keep their contents. A following write starts a new load.
- R5: Outputs change only on the clock edge of a committing write. After one to four accepted writes of a load they still show the previous values.
- R6: `mirror_mode` equals control bits [1:0]: 0 is one-screen low, 1 is one-screen high, 2 is vertical, 3 is horizontal.
- R7: `prg_mode` is 0 (32 KB switching) when control bits [3:2] are 0 or 1. It is 2 (first bank fixed) when they are 2, and 3 (last bank fixed) when they are 3. It never reads 1.
- R8: `chr_split` equals control bit 4: 0 is one 8 KB bank, 1 is two independent 4 KB banks.
- R9: The program bank register drives `prg_bank` from its bits [3:0]. It drives `wram_en` as the inverse of its bit 4.
- R10: A write with `wr_addr[15]`=0, or any cycle with `wr_en`=0, leaves the collector and all registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe, sampled on each rising edge |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data; bit 0 payload, bit 7 abort |
| mirror_mode | output | 2 | Nametable mirroring selection |
| prg_mode | output | 2 | Program bank mode (0, 2 or 3) |
| chr_split | output | 1 | Character banking in two 4 KB halves |
| chr_bank_lo | output | 5 | Low character bank number |
| chr_bank_hi | output | 5 | High character bank number |
| prg_bank | output | 4 | Program bank number |
| wram_en | output | 1 | Work RAM enable |

## Verification
A collector that loses or gains a bit moves every later bit by one position, and it commits one write early or late. This shows on the ports at the very next commit, as a value that is doubled, halved or sent to the wrong register. An abort or ignore path that is broken leaves stale bits behind, and the next five-write load then lands with a corrupted value. Every output is therefore compared right after each commit edge. It is also compared after the fourth write of each load, which catches commits that come too early.

// File: rtl/bankcfg_pkg.sv
package bankcfg_pkg;
  localparam int unsigned ADDR_W  = 16;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned SER_LEN = 5;
  localparam int unsigned PRG_W   = 4;
  localparam int unsigned NREGS   = 4;
  localparam int unsigned ABORT_BIT = 7;

  typedef enum logic [1:0] {
    MIR_ONE_LOW  = 2'd0,
    MIR_ONE_HIGH = 2'd1,
    MIR_VERT     = 2'd2,
    MIR_HORZ     = 2'd3
  } mirror_e;

  typedef enum logic [1:0] {
    PRG_WIDE       = 2'd0,
    PRG_LOW_FIXED  = 2'd2,
    PRG_HIGH_FIXED = 2'd3
  } prg_mode_e;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CHRL = 2'd1,
    SEL_CHRH = 2'd2,
    SEL_PRG  = 2'd3
  } target_e;
endpackage

// File: rtl/serial_gather.sv
module serial_gather #(
  parameter int unsigned LEN = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           escape,
  input  logic           bit_in,
  output logic           commit,
  output logic [LEN-1:0] word
);
  localparam logic [LEN-1:0] EMPTY = {1'b1, {(LEN-1){1'b0}}};

  logic [LEN-1:0] sr_q;

  // Marker-bit shift: the marker reaches bit 0 after LEN-1 payload bits.
  assign word   = {bit_in, sr_q[LEN-1:1]};
  assign commit = shift_en && !escape && sr_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q <= EMPTY;
    end else if (shift_en) begin
      if (escape || sr_q[0]) sr_q <= EMPTY;
      else                   sr_q <= word;
    end
  end

  AST_MARKER_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    sr_q != '0); // R3
  AST_ESCAPE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && escape) |=> (sr_q == EMPTY)); // R2
  AST_COMMIT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (sr_q == EMPTY && !commit)); // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(sr_q)); // R10
endmodule

// File: rtl/cfg_file.sv
module cfg_file
  import bankcfg_pkg::*;
#(
  parameter int unsigned LEN = SER_LEN,
  parameter int unsigned NR  = NREGS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  commit,
  input  logic [$clog2(NR)-1:0] sel,
  input  logic [LEN-1:0]        word,
  output logic [LEN-1:0]        ctrl_q,
  output logic [LEN-1:0]        chrl_q,
  output logic [LEN-1:0]        chrh_q,
  output logic [LEN-1:0]        prg_q
);
  logic [LEN-1:0] regs_q [NR];

  function automatic logic [LEN-1:0] rst_val(input int idx);
    logic [LEN-1:0] v;
    v = '0;
    if (idx == int'(SEL_CTRL)) v[3:2] = 2'b11;   // last bank fixed
    if (idx == int'(SEL_PRG))  v[LEN-1] = 1'b1;  // work RAM off
    return v;
  endfunction

  for (genvar i = 0; i < NR; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                                   regs_q[i] <= rst_val(i);
      else if (commit && sel == ($clog2(NR))'(i))   regs_q[i] <= word;
    end

    AST_OTHER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!commit || sel != ($clog2(NR))'(i)) |=> $stable(regs_q[i])); // R5
    AST_TARGET_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && sel == ($clog2(NR))'(i)) |=> (regs_q[i] == $past(word))); // R4
  end

  assign ctrl_q = regs_q[SEL_CTRL];
  assign chrl_q = regs_q[SEL_CHRL];
  assign chrh_q = regs_q[SEL_CHRH];
  assign prg_q  = regs_q[SEL_PRG];
endmodule

// File: rtl/cfg_decode.sv
module cfg_decode
  import bankcfg_pkg::*;
#(
  parameter int unsigned LEN = SER_LEN,
  parameter int unsigned PW  = PRG_W
) (
  input  logic [LEN-1:0] ctrl_q,
  input  logic [LEN-1:0] prg_q,
  output logic [1:0]     mirror_mode,
  output logic [1:0]     prg_mode,
  output logic           chr_split,
  output logic [PW-1:0]  prg_bank,
  output logic           wram_en
);
  always_comb begin
    mirror_mode = ctrl_q[1:0];
    chr_split   = ctrl_q[4];
    unique case (ctrl_q[3:2])
      2'd2:    prg_mode = PRG_LOW_FIXED;
      2'd3:    prg_mode = PRG_HIGH_FIXED;
      default: prg_mode = PRG_WIDE;
    endcase
    prg_bank = prg_q[PW-1:0];
    wram_en  = !prg_q[LEN-1];
  end
endmodule

// File: rtl/bank_cfg_serial.sv
module bank_cfg_serial
  import bankcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [1:0]        mirror_mode,
  output logic [1:0]        prg_mode,
  output logic              chr_split,
  output logic [SER_LEN-1:0] chr_bank_lo,
  output logic [SER_LEN-1:0] chr_bank_hi,
  output logic [PRG_W-1:0]  prg_bank,
  output logic              wram_en
);
  localparam int unsigned SEL_W = $clog2(NREGS);

  logic               in_window;
  logic               commit;
  logic [SER_LEN-1:0] word;
  logic [SER_LEN-1:0] ctrl_q, prg_q;
  logic               unused_bits;

  assign in_window   = wr_en && wr_addr[ADDR_W-1];
  assign unused_bits = ^{wr_addr[ADDR_W-SEL_W-2:0], wr_data[ABORT_BIT-1:1]};

  serial_gather #(.LEN(SER_LEN)) u_gather (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (in_window),
    .escape   (wr_data[ABORT_BIT]),
    .bit_in   (wr_data[0]),
    .commit   (commit),
    .word     (word)
  );

  cfg_file #(.LEN(SER_LEN), .NR(NREGS)) u_file (
    .clk    (clk),
    .rst_n  (rst_n),
    .commit (commit),
    .sel    (wr_addr[ADDR_W-2 -: SEL_W]),
    .word   (word),
    .ctrl_q (ctrl_q),
    .chrl_q (chr_bank_lo),
    .chrh_q (chr_bank_hi),
    .prg_q  (prg_q)
  );

  cfg_decode #(.LEN(SER_LEN), .PW(PRG_W)) u_decode (
    .ctrl_q      (ctrl_q),
    .prg_q       (prg_q),
    .mirror_mode (mirror_mode),
    .prg_mode    (prg_mode),
    .chr_split   (chr_split),
    .prg_bank    (prg_bank),
    .wram_en     (wram_en)
  );

  AST_PRG_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    prg_mode != 2'd1); // R7
  AST_LOW_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr[ADDR_W-1]) |=> ($stable(ctrl_q) && $stable(prg_q))); // R10
endmodule

// File: tb/tb_bank_cfg_serial.sv
`timescale 1ns/1ps
module tb_bank_cfg_serial;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [1:0]  mirror_mode, prg_mode;
  logic        chr_split, wram_en;
  logic [4:0]  chr_bank_lo, chr_bank_hi;
  logic [3:0]  prg_bank;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [4:0] e_ctrl, e_lo, e_hi, e_prg;

  always #4 clk = ~clk;

  bank_cfg_serial dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mirror_mode(mirror_mode), .prg_mode(prg_mode), .chr_split(chr_split),
    .chr_bank_lo(chr_bank_lo), .chr_bank_hi(chr_bank_hi), .prg_bank(prg_bank),
    .wram_en(wram_en)
  );

  function automatic logic [19:0] expected();
    logic [1:0] pm;
    pm = (e_ctrl[3:2] < 2) ? 2'd0 : e_ctrl[3:2];
    return {e_ctrl[1:0], pm, e_ctrl[4], e_lo, e_hi, e_prg[3:0], ~e_prg[4]};
  endfunction

  function automatic logic [19:0] observed();
    return {mirror_mode, prg_mode, chr_split, chr_bank_lo, chr_bank_hi, prg_bank, wram_en};
  endfunction

  task automatic chk(input string tag);
    logic [19:0] got, exp;
    got = observed();
    exp = expected();
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%05h exp=%05h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic commit_model(input int t, input logic [4:0] v);
    case (t)
      0: e_ctrl = v;
      1: e_lo   = v;
      2: e_hi   = v;
      default: e_prg = v;
    endcase
  endtask

  // Writes bits lo..hi of v LSB first; payload-free bits 6:1 carry junk (R3)
  task automatic send_bits(input logic [15:0] a, input logic [4:0] v, input int lo, input int hi);
    for (int i = lo; i <= hi; i++)
      wr(a, {1'b0, 6'((v * 7 + i * 13) & 63), v[i]});
  endtask

  initial begin
    e_ctrl = 5'b01100; e_lo = '0; e_hi = '0; e_prg = 5'b10000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset state");

    // Sweep every target and every value: R3 R4 R5 R6 R7 R8 R9
    for (int t = 0; t < 4; t++) begin
      for (int v = 0; v < 32; v++) begin
        logic [15:0] a;
        a = 16'h8000 + 16'(t * 16'h2000) + 16'((v * 16'h0107) & 16'h1FFF);
        send_bits(a, 5'(v), 0, 3);
        chk("R5 no commit before fifth write");
        send_bits(a, 5'(v), 4, 4);
        commit_model(t, 5'(v));
        chk("R4 R6 R7 R8 R9 commit sweep");
      end
    end

    // R2: abort after three bits, then a fresh load to low chr bank
    send_bits(16'h8123, 5'b10110, 0, 2);
    wr(16'hF000, 8'h80);
    chk("R2 abort commits nothing");
    send_bits(16'hA555, 5'b01011, 0, 4);
    e_lo = 5'b01011;
    chk("R2 load after abort");

    // R2: abort in the fifth slot
    send_bits(16'hE000, 5'b00101, 0, 3);
    wr(16'hE000, 8'h81);
    chk("R2 abort in fifth slot");
    send_bits(16'hE001, 5'b00101, 0, 4);
    e_prg = 5'b00101;
    chk("R2 R9 load after late abort");

    // R10: low-address writes and unstrobed cycles mid-load are ignored
    send_bits(16'hC000, 5'b11001, 0, 1);
    wr(16'h7FFF, 8'h81);
    wr(16'h0000, 8'h01);
    @(negedge clk);
    wr_addr = 16'hC000; wr_data = 8'h01;
    @(negedge clk);
    @(negedge clk);
    chk("R10 ignored writes leave outputs");
    send_bits(16'hC000, 5'b11001, 2, 4);
    e_hi = 5'b11001;
    chk("R10 load completes with ignored writes skipped");

    // R1: reset mid-load returns defaults and empties collector
    send_bits(16'h8000, 5'b11111, 0, 2);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    e_ctrl = 5'b01100; e_lo = '0; e_hi = '0; e_prg = 5'b10000;
    @(negedge clk);
    chk("R1 reset defaults again");
    send_bits(16'h9000, 5'b10011, 0, 4);
    e_ctrl = 5'b10011;
    chk("R1 R6 R8 collector empty after reset");

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog got=running exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule